// File: doc/BRIEF.md
# Segmented Logical-to-Linear Address Translator

This block turns a logical address, made of a segment register number and a 32-bit offset, into a 32-bit linear address. It holds six cached segment descriptors, numbered 0 to 5. Each descriptor carries a base, a 20-bit limit, a granularity flag, a present flag and a null flag. A translation reads only this cache and never walks a descriptor table. A load port writes a cached descriptor, and it accepts a null descriptor without complaint.

For each access request, the block selects a cached descriptor and adds the offset to its base. It checks that the last byte touched by the access lies within the effective segment limit. The result comes back one clock later as a linear address and a two-bit fault code. A register that holds a null descriptor is only reported when it is used for an access, not when it is loaded.

Top module: `seg_xlat`

## Requirements
- R1: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high. While `rsp_valid` is low, `linear` and `fault_code` are 0.
- R2: When an access has no fault, `linear` equals the selected base plus `offset`, modulo 2^32. Wrap-around past 2^32 is not a fault.
- R3: With the granularity flag at 0, the effective limit is the 20-bit limit, counted in bytes and zero-extended.
- R4: With the granularity flag at 1, the effective limit is (limit << 12) | 0xFFF.
- R5: The size code sets the access width: 0 is 1 byte, 1 is 2 bytes, and 2 or 3 is 4 bytes. A limit fault (code 3) occurs when offset + bytes - 1 exceeds the effective limit. This sum is computed without 32-bit wrap.
- R6: An access through a register whose null flag is set gives fault code 1. This code takes priority over every other fault.
- R7: An access through a non-null register whose present flag is clear gives fault code 2. This code takes priority over a limit fault.
- R8: `fault_code` 0 means no fault. Whenever `fault_code` is non-zero, `linear` is 0.
- R9: After reset, every cached register holds a null descriptor, so any access faults with code 1.
- R10: A load with `ld_valid` writes the register named by `ld_idx` at the clock edge. An access in the same cycle still sees the old contents. A load with `ld_idx` of 6 or 7 changes nothing.
- R11: An access with `seg_sel` of 6 or 7 gives fault code 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Write a cached descriptor |
| ld_idx | input | 3 | Register number to write |
| ld_base | input | 32 | Segment base to store |
| ld_limit | input | 20 | Raw segment limit to store |
| ld_gran | input | 1 | Granularity flag to store |
| ld_present | input | 1 | Present flag to store |
| ld_null | input | 1 | Null flag to store |
| req_valid | input | 1 | Access request strobe |
| seg_sel | input | 3 | Register number used by the access |
| offset | input | 32 | Offset within the segment |
| size | input | 2 | Access width code |
| rsp_valid | output | 1 | Response strobe |
| linear | output | 32 | Linear address |
| fault_code | output | 2 | 0 none, 1 null, 2 not present, 3 limit |

## Verification
A request driven before a rising edge is registered at that edge. The bench therefore drives each request at a falling edge, then samples `rsp_valid`, `linear` and `fault_code` at the next falling edge, one full cycle later. Loads take effect at the edge that registers them, so a same-cycle load and access must show the old descriptor. The bench checks that case and then repeats the access to see the new contents. Sweeps cover every register number and size code, at offsets around each effective limit and at the top of the address space.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;

    localparam int ADDR_W     = 32;
    localparam int LIM_W      = 20;
    localparam int GRAN_SHIFT = ADDR_W - LIM_W;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [LIM_W-1:0]  limit;
        logic              gran;
        logic              present;
        logic              null_sel;
    } seg_desc_t;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_NULL    = 2'd1,
        FLT_ABSENT  = 2'd2,
        FLT_LIMIT   = 2'd3
    } fault_e;

    localparam seg_desc_t DESC_RESET = '{base: '0, limit: '0, gran: 1'b0,
                                         present: 1'b0, null_sel: 1'b1};

    function automatic logic [2:0] size_bytes(input logic [1:0] code);
        case (code)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] eff_limit(input seg_desc_t d);
        if (d.gran)
            return {d.limit, {GRAN_SHIFT{1'b1}}};
        return {{GRAN_SHIFT{1'b0}}, d.limit};
    endfunction

endpackage

// File: rtl/seg_cache.sv
module seg_cache
    import seg_xlat_pkg::*;
#(
    parameter int NUM_SEG = 6,
    parameter int IDX_W   = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  seg_desc_t        wr_desc,
    input  logic [IDX_W-1:0] rd_idx,
    output seg_desc_t        rd_desc,
    output logic             rd_ok
);
    seg_desc_t entry [NUM_SEG];

    for (genvar i = 0; i < NUM_SEG; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst)
                entry[i] <= DESC_RESET;
            else if (wr_en && wr_idx == IDX_W'(i))
                entry[i] <= wr_desc;
        end
    end

    always_comb begin
        rd_desc = DESC_RESET;
        rd_ok   = 1'b0;
        for (int i = 0; i < NUM_SEG; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_desc = entry[i];
                rd_ok   = 1'b1;
            end
        end
    end
endmodule

// File: rtl/seg_limit_chk.sv
module seg_limit_chk
    import seg_xlat_pkg::*;
(
    input  seg_desc_t         desc,
    input  logic [ADDR_W-1:0] offset,
    input  logic [1:0]        size,
    output logic              over
);
    logic [ADDR_W-1:0] lim;
    logic [ADDR_W:0]   last_byte;

    always_comb begin
        lim       = eff_limit(desc);
        last_byte = {1'b0, offset} + (ADDR_W+1)'(size_bytes(size)) - (ADDR_W+1)'(1);
        over      = last_byte > {1'b0, lim};
    end

    always_comb begin
        if (!desc.gran)
            assert (lim[ADDR_W-1:LIM_W] == '0) else $error("AST_BYTE_LIMIT_NARROW"); // R3
    end
endmodule

// File: rtl/seg_xlat.sv
module seg_xlat
    import seg_xlat_pkg::*;
#(
    parameter int NUM_SEG = 6,
    localparam int IDX_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_valid,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [ADDR_W-1:0] ld_base,
    input  logic [LIM_W-1:0]  ld_limit,
    input  logic              ld_gran,
    input  logic              ld_present,
    input  logic              ld_null,
    input  logic              req_valid,
    input  logic [IDX_W-1:0]  seg_sel,
    input  logic [ADDR_W-1:0] offset,
    input  logic [1:0]        size,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] linear,
    output logic [1:0]        fault_code
);
    seg_desc_t wr_desc, sel_desc;
    logic      sel_ok, lim_over;
    fault_e    flt;

    assign wr_desc = '{base: ld_base, limit: ld_limit, gran: ld_gran,
                       present: ld_present, null_sel: ld_null};

    seg_cache #(.NUM_SEG(NUM_SEG), .IDX_W(IDX_W)) u_cache (
        .clk(clk), .rst(rst),
        .wr_en(ld_valid), .wr_idx(ld_idx), .wr_desc(wr_desc),
        .rd_idx(seg_sel), .rd_desc(sel_desc), .rd_ok(sel_ok)
    );

    seg_limit_chk u_lim (
        .desc(sel_desc), .offset(offset), .size(size), .over(lim_over)
    );

    always_comb begin
        if (!sel_ok || sel_desc.null_sel) flt = FLT_NULL;
        else if (!sel_desc.present)       flt = FLT_ABSENT;
        else if (lim_over)                flt = FLT_LIMIT;
        else                              flt = FLT_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            linear     <= '0;
            fault_code <= FLT_NONE;
        end else begin
            rsp_valid  <= req_valid;
            fault_code <= req_valid ? flt : FLT_NONE;
            linear     <= (req_valid && flt == FLT_NONE) ? sel_desc.base + offset : '0;
        end
    end

    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid); // R1
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_valid && linear == '0 && fault_code == 2'd0)); // R1
    AST_FAULT_ZERO_LINEAR: assert property (@(posedge clk) disable iff (rst)
        (fault_code != 2'd0) |-> (linear == '0 && rsp_valid)); // R8
    AST_BAD_SEL_NULL: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !sel_ok) |=> fault_code == 2'd1); // R11
endmodule

// File: tb/sim_seg_xlat.sv
module sim_seg_xlat;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_valid = 0, ld_gran = 0, ld_present = 0, ld_null = 0;
    logic [2:0]  ld_idx = 0, seg_sel = 0;
    logic [31:0] ld_base = 0, offset = 0;
    logic [19:0] ld_limit = 0;
    logic        req_valid = 0;
    logic [1:0]  size = 0;
    logic        rsp_valid;
    logic [31:0] linear;
    logic [1:0]  fault_code;

    int checks = 0, failures = 0;
    bit done = 0;

    logic [31:0] m_base [6];
    logic [19:0] m_lim  [6];
    logic        m_gran [6], m_pres [6], m_null [6];

    always #4 clk = ~clk;

    seg_xlat u0 (.*);

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load(input int idx, input logic [31:0] b, input logic [19:0] l,
                        input logic g, input logic p, input logic n);
        @(negedge clk);
        ld_valid = 1; ld_idx = 3'(idx); ld_base = b; ld_limit = l;
        ld_gran = g; ld_present = p; ld_null = n;
        @(negedge clk);
        ld_valid = 0;
        if (idx < 6) begin
            m_base[idx] = b; m_lim[idx] = l; m_gran[idx] = g;
            m_pres[idx] = p; m_null[idx] = n;
        end
    endtask

    function automatic logic [33:0] expect_rsp(input int s, input logic [31:0] off, input logic [1:0] sz);
        logic [32:0] eff, last;
        int bytes;
        bytes = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        if (s >= 6 || m_null[s]) return {2'd1, 32'd0};
        if (!m_pres[s]) return {2'd2, 32'd0};
        eff  = m_gran[s] ? {1'b0, m_lim[s], 12'hFFF} : {13'd0, m_lim[s]};
        last = {1'b0, off} + 33'(bytes) - 33'd1;
        if (last > eff) return {2'd3, 32'd0};
        return {2'd0, m_base[s] + off};
    endfunction

    task automatic access(input string req, input int s, input logic [31:0] off, input logic [1:0] sz);
        logic [33:0] e;
        e = expect_rsp(s, off, sz);
        @(negedge clk);
        req_valid = 1; seg_sel = 3'(s); offset = off; size = sz;
        @(negedge clk);
        req_valid = 0;
        check({req, " valid R1"}, 64'(rsp_valid), 64'd1);
        check({req, " fault"}, 64'(fault_code), 64'(e[33:32]));
        check({req, " linear"}, 64'(linear), 64'(e[31:0]));
    endtask

    task automatic sweep();
        logic [31:0] eff;
        logic [31:0] offs [8];
        for (int s = 0; s < 8; s++) begin
            eff = (s < 6) ? (m_gran[s] ? {m_lim[s], 12'hFFF} : {12'd0, m_lim[s]}) : 32'd0;
            offs[0] = 0; offs[1] = eff - 4; offs[2] = eff - 3; offs[3] = eff - 1;
            offs[4] = eff; offs[5] = eff + 1; offs[6] = 32'hFFFF_FFFF; offs[7] = 32'hFFFF_FFFE;
            for (int k = 0; k < 8; k++)
                for (int z = 0; z < 4; z++)
                    access("R2 R3 R4 R5 R6 R7 R8 R11 sweep", s, offs[k], 2'(z));
        end
    endtask

    initial begin
        for (int i = 0; i < 6; i++) begin
            m_base[i] = 0; m_lim[i] = 0; m_gran[i] = 0; m_pres[i] = 0; m_null[i] = 1;
        end
        repeat (3) @(negedge clk);
        rst = 0;
        check("R9 reset rsp_valid", 64'(rsp_valid), 64'd0);
        check("R9 reset fault", 64'(fault_code), 64'd0);
        for (int s = 0; s < 6; s++) access("R9 reset null", s, 32'h10, 2'd0);
        @(negedge clk);
        check("R1 idle valid", 64'(rsp_valid), 64'd0);
        check("R1 idle linear", 64'(linear), 64'd0);

        load(0, 32'h0000_1000, 20'h00FFF, 0, 1, 0);
        load(1, 32'hFFFF_FF00, 20'h00200, 0, 1, 0);
        load(2, 32'h0004_0000, 20'h00003, 1, 1, 0);
        load(3, 32'h0000_2000, 20'h0FFFF, 0, 0, 0);
        load(4, 32'h0000_3000, 20'hFFFFF, 1, 1, 1);
        load(5, 32'h0000_0010, 20'hFFFFF, 1, 1, 0);
        sweep();

        access("R2 wrap", 1, 32'h0000_0180, 2'd2);
        access("R5 top", 5, 32'hFFFF_FFFF, 2'd2);

        load(7, 32'hDEAD_0000, 20'h00001, 0, 0, 1);
        load(6, 32'hDEAD_0000, 20'h00001, 0, 0, 1);
        for (int s = 0; s < 6; s++) access("R10 ignored load", s, 32'h0, 2'd0);

        @(negedge clk);
        ld_valid = 1; ld_idx = 0; ld_base = 32'h5; ld_limit = 20'h1;
        ld_gran = 0; ld_present = 1; ld_null = 1;
        req_valid = 1; seg_sel = 0; offset = 32'h8; size = 2'd0;
        @(negedge clk);
        ld_valid = 0; req_valid = 0;
        check("R10 same-cycle old fault", 64'(fault_code), 64'd0);
        check("R10 same-cycle old linear", 64'(linear), 64'h1008);
        m_base[0] = 32'h5; m_lim[0] = 20'h1; m_gran[0] = 0; m_pres[0] = 1; m_null[0] = 1;
        access("R6 R10 new null", 0, 32'h8, 2'd0);

        load(0, 32'h8000_0000, 20'hFFFFF, 0, 1, 0);
        load(2, 32'h0, 20'h00000, 1, 1, 0);
        load(3, 32'h100, 20'h00010, 0, 1, 0);
        load(4, 32'h200, 20'h00010, 0, 0, 0);
        sweep();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule